// File: doc/BRIEF.md
# CPU Status Latch and Bus Control Driver

This block joins an 8080-style processor to a shared system bus. When the processor opens a machine cycle it places a status byte on its data lines and raises SYNC. The block passes SYNC through a short synchronizer. On the clock edge where the synchronized SYNC is high and phi2 is low, it latches all data lines into a status register. That edge falls in the middle of the SYNC pulse. The latched byte is then presented to the bus together with an output enable.

The block also forwards the processor control lines (SYNC, INTE, HLDA, WR, WAIT) to the bus. It produces the bus data-in strobe, which is the processor DBIN merged with an active-low override from an external DMA device. It drives the outbound data byte as well. Each of the three driver groups is modelled as a value plus an enable, and each group has its own active-low disable line. Any bus master that takes over the bus can silence that group. The outbound data enable is also dropped whenever the processor reads from an on-board source, so the block never drives and receives at the same time.

Top module: `bus_stat_drv`

## Requirements
- R1: On a rising clock edge where the synchronized SYNC (SYNC delayed by SYNC_STAGES clocks, 1 by default) is high and phi2 is low, all DATA_W bits of cpu_data are stored in the status register. The new value appears on bus_stat after that edge.
- R2: On any other edge the status register keeps its value. This covers edges where phi2 is high and edges where the synchronized SYNC is low, whatever cpu_data holds.
- R3: While rst_n is low the status register and the SYNC synchronizer clear to 0, so bus_stat reads 8'h00 after reset.
- R4: bus_stat_oe equals stat_dis_n in the same cycle. A low on stat_dis_n turns off the status drivers with no clock delay.
- R5: bus_pdbin is high when dbin is high or when dma_in_n is low, and is low otherwise.
- R6: bus_sync, bus_inte, bus_hlda, bus_wr and bus_wait copy sync, inte, hlda, wr and wait_in. bus_ctl_oe equals ctl_dis_n in the same cycle. When HAS_CTL_DIS is 0 there is no disable source, and bus_ctl_oe is held at 1, as a pulled-up line would be.
- R7: bus_dout copies cpu_data. bus_dout_oe is 1 by default and goes to 0 in the same cycle that dout_dis_n is low.
- R8: bus_dout_oe is 0 whenever dbin is high and at least one bit of src_sel (the on-board read-source selects) is 1. If dbin is high with src_sel all zero, the read targets the external bus and bus_dout_oe stays 1. dma_in_n alone does not affect bus_dout_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Processor SYNC, start of machine cycle |
| phi2 | input | 1 | Processor phase-2 clock level |
| dbin | input | 1 | Processor data-in strobe |
| wr | input | 1 | Processor write strobe |
| inte | input | 1 | Processor interrupt enable |
| hlda | input | 1 | Processor hold acknowledge |
| wait_in | input | 1 | Processor wait state |
| cpu_data | input | DATA_W | Processor data lines |
| src_sel | input | NUM_SRC | On-board read-source selects, one bit per source |
| stat_dis_n | input | 1 | Active-low status driver disable |
| ctl_dis_n | input | 1 | Active-low control driver disable |
| dout_dis_n | input | 1 | Active-low data-out driver disable |
| dma_in_n | input | 1 | Active-low external data-in strobe override |
| bus_stat | output | DATA_W | Latched status byte |
| bus_stat_oe | output | 1 | Status driver enable |
| bus_sync | output | 1 | SYNC to bus |
| bus_inte | output | 1 | INTE to bus |
| bus_hlda | output | 1 | HLDA to bus |
| bus_wr | output | 1 | WR to bus |
| bus_wait | output | 1 | WAIT to bus |
| bus_pdbin | output | 1 | Merged data-in strobe to bus |
| bus_ctl_oe | output | 1 | Control driver enable |
| bus_dout | output | DATA_W | Outbound data byte |
| bus_dout_oe | output | 1 | Outbound data driver enable |

## Verification
The hardest case to reach is proving that a status capture never happens on a phi2-high edge while SYNC is held high. The synchronizer delay means the synchronized SYNC lags the port by one clock. The stimulus therefore holds SYNC high with phi2 high for several edges while the data lines change. It then drops SYNC and waits until the synchronizer has flushed before lowering phi2. Only after that does it open a proper window, and it checks the register before and after.

// File: rtl/bus_stat_drv_pkg.sv
package bus_stat_drv_pkg;

   typedef struct packed {
      logic sync;
      logic inte;
      logic hlda;
      logic wr;
      logic wt;
   } ctl_lines_t;

   localparam int CTL_LINES = $bits(ctl_lines_t);

endpackage

// File: rtl/bsd_stat_latch.sv
module bsd_stat_latch #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              phi2,
   input  logic [DATA_W-1:0] data_in,
   output logic              sync_s,
   output logic [DATA_W-1:0] stat_q
);

   logic [SYNC_STAGES-1:0] sync_pipe;
   logic                   strobe;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_pipe <= '0;
            else        sync_pipe <= sync;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_pipe <= '0;
            else        sync_pipe <= {sync_pipe[SYNC_STAGES-2:0], sync};
         end
      end
   endgenerate

   assign sync_s = sync_pipe[SYNC_STAGES-1];
   assign strobe = sync_s & ~phi2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q <= '0;
      else if (strobe) stat_q <= data_in;
   end

endmodule

// File: rtl/bsd_ctl_drive.sv
module bsd_ctl_drive
   import bus_stat_drv_pkg::*;
#(
   parameter bit HAS_CTL_DIS = 1'b1
) (
   input  ctl_lines_t cpu_ctl,
   input  logic       dbin,
   input  logic       dma_in_n,
   input  logic       ctl_dis_n,
   output ctl_lines_t bus_ctl,
   output logic       pdbin,
   output logic       ctl_oe
);

   assign bus_ctl = cpu_ctl;
   assign pdbin   = dbin | ~dma_in_n;

   generate
      if (HAS_CTL_DIS) begin : g_dis_pin
         assign ctl_oe = ctl_dis_n;
      end else begin : g_pulled_up
         assign ctl_oe = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/bsd_dout_drive.sv
module bsd_dout_drive #(
   parameter int DATA_W  = 8,
   parameter int NUM_SRC = 3
) (
   input  logic               dbin,
   input  logic [NUM_SRC-1:0] src_sel,
   input  logic               dout_dis_n,
   input  logic [DATA_W-1:0]  data_in,
   output logic [DATA_W-1:0]  dout,
   output logic               dout_oe
);

   logic onboard_read;

   assign onboard_read = dbin & (|src_sel);
   assign dout         = data_in;
   assign dout_oe      = dout_dis_n & ~onboard_read;

endmodule

// File: rtl/bus_stat_drv.sv
module bus_stat_drv
   import bus_stat_drv_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NUM_SRC     = 3,
   parameter int SYNC_STAGES = 1,
   parameter bit HAS_CTL_DIS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync,
   input  logic               phi2,
   input  logic               dbin,
   input  logic               wr,
   input  logic               inte,
   input  logic               hlda,
   input  logic               wait_in,
   input  logic [DATA_W-1:0]  cpu_data,
   input  logic [NUM_SRC-1:0] src_sel,
   input  logic               stat_dis_n,
   input  logic               ctl_dis_n,
   input  logic               dout_dis_n,
   input  logic               dma_in_n,
   output logic [DATA_W-1:0]  bus_stat,
   output logic               bus_stat_oe,
   output logic               bus_sync,
   output logic               bus_inte,
   output logic               bus_hlda,
   output logic               bus_wr,
   output logic               bus_wait,
   output logic               bus_pdbin,
   output logic               bus_ctl_oe,
   output logic [DATA_W-1:0]  bus_dout,
   output logic               bus_dout_oe
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("NUM_SRC must be at least 1");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
         $error("SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic       sync_s;
   ctl_lines_t cpu_ctl;
   ctl_lines_t out_ctl;

   bsd_stat_latch #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync    (sync),
      .phi2    (phi2),
      .data_in (cpu_data),
      .sync_s  (sync_s),
      .stat_q  (bus_stat)
   );

   assign bus_stat_oe = stat_dis_n;

   assign cpu_ctl = '{sync: sync, inte: inte, hlda: hlda, wr: wr, wt: wait_in};

   bsd_ctl_drive #(
      .HAS_CTL_DIS (HAS_CTL_DIS)
   ) u_ctl (
      .cpu_ctl   (cpu_ctl),
      .dbin      (dbin),
      .dma_in_n  (dma_in_n),
      .ctl_dis_n (ctl_dis_n),
      .bus_ctl   (out_ctl),
      .pdbin     (bus_pdbin),
      .ctl_oe    (bus_ctl_oe)
   );

   assign bus_sync = out_ctl.sync;
   assign bus_inte = out_ctl.inte;
   assign bus_hlda = out_ctl.hlda;
   assign bus_wr   = out_ctl.wr;
   assign bus_wait = out_ctl.wt;

   bsd_dout_drive #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC)
   ) u_dout (
      .dbin       (dbin),
      .src_sel    (src_sel),
      .dout_dis_n (dout_dis_n),
      .data_in    (cpu_data),
      .dout       (bus_dout),
      .dout_oe    (bus_dout_oe)
   );

endmodule

// File: rtl/bus_stat_drv_chk.sv
module bus_stat_drv_chk #(
   parameter int DATA_W  = 8,
   parameter int NUM_SRC = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sync_s,
   input logic               phi2,
   input logic               dbin,
   input logic               dma_in_n,
   input logic [DATA_W-1:0]  cpu_data,
   input logic [NUM_SRC-1:0] src_sel,
   input logic               stat_dis_n,
   input logic               ctl_dis_n,
   input logic               dout_dis_n,
   input logic [DATA_W-1:0]  bus_stat,
   input logic               bus_stat_oe,
   input logic               bus_pdbin,
   input logic               bus_ctl_oe,
   input logic               bus_dout_oe
);

   AST_CAPTURE_MID_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_s && !phi2) |=> (bus_stat == $past(cpu_data))); // R1

   AST_HOLD_OUTSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_s && !phi2) |=> $stable(bus_stat)); // R2

   AST_STAT_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stat_oe == stat_dis_n); // R4

   AST_PDBIN_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pdbin == (dbin || !dma_in_n)); // R5

   AST_CTL_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_dis_n |-> !bus_ctl_oe); // R6

   AST_DOUT_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_dis_n |-> !bus_dout_oe); // R7

   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (dbin && (src_sel != '0)) |-> !bus_dout_oe); // R8

endmodule

bind bus_stat_drv bus_stat_drv_chk #(
   .DATA_W  (DATA_W),
   .NUM_SRC (NUM_SRC)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_s      (sync_s),
   .phi2        (phi2),
   .dbin        (dbin),
   .dma_in_n    (dma_in_n),
   .cpu_data    (cpu_data),
   .src_sel     (src_sel),
   .stat_dis_n  (stat_dis_n),
   .ctl_dis_n   (ctl_dis_n),
   .dout_dis_n  (dout_dis_n),
   .bus_stat    (bus_stat),
   .bus_stat_oe (bus_stat_oe),
   .bus_pdbin   (bus_pdbin),
   .bus_ctl_oe  (bus_ctl_oe),
   .bus_dout_oe (bus_dout_oe)
);

// File: tb/test_bus_stat_drv.sv
module test_bus_stat_drv;

   localparam int DW = 8;
   localparam int NS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync = 1'b0, phi2 = 1'b0, dbin = 1'b0, wr = 1'b0;
   logic          inte = 1'b0, hlda = 1'b0, wait_in = 1'b0;
   logic [DW-1:0] cpu_data = '0;
   logic [NS-1:0] src_sel = '0;
   logic          stat_dis_n = 1'b1, ctl_dis_n = 1'b1, dout_dis_n = 1'b1, dma_in_n = 1'b1;
   logic [DW-1:0] bus_stat, bus_dout;
   logic          bus_stat_oe, bus_sync, bus_inte, bus_hlda, bus_wr, bus_wait;
   logic          bus_pdbin, bus_ctl_oe, bus_dout_oe;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bus_stat_drv i_bus_stat_drv (
      .clk(clk), .rst_n(rst_n), .sync(sync), .phi2(phi2), .dbin(dbin), .wr(wr),
      .inte(inte), .hlda(hlda), .wait_in(wait_in), .cpu_data(cpu_data),
      .src_sel(src_sel), .stat_dis_n(stat_dis_n), .ctl_dis_n(ctl_dis_n),
      .dout_dis_n(dout_dis_n), .dma_in_n(dma_in_n), .bus_stat(bus_stat),
      .bus_stat_oe(bus_stat_oe), .bus_sync(bus_sync), .bus_inte(bus_inte),
      .bus_hlda(bus_hlda), .bus_wr(bus_wr), .bus_wait(bus_wait),
      .bus_pdbin(bus_pdbin), .bus_ctl_oe(bus_ctl_oe), .bus_dout(bus_dout),
      .bus_dout_oe(bus_dout_oe)
   );

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      step(1);
      chk("R3 status during reset", bus_stat, 8'h00);
      rst_n = 1'b1;
      cpu_data = 8'hA5;
      step(2);
      chk("R3 status after reset", bus_stat, 8'h00);
   endtask

   task automatic t_capture;
      sync = 1'b1; phi2 = 1'b1; cpu_data = 8'h3C;
      step(1);
      chk("R2 no capture while phi2 high", bus_stat, 8'h00);
      phi2 = 1'b0; cpu_data = 8'hA2;
      step(1);
      chk("R1 capture mid-SYNC", bus_stat, 8'hA2);
      sync = 1'b0; phi2 = 1'b1; cpu_data = 8'h11;
      step(2);
      chk("R2 hold after SYNC ends", bus_stat, 8'hA2);
   endtask

   task automatic t_phi2_high;
      sync = 1'b1; phi2 = 1'b1;
      for (int i = 0; i < 4; i++) begin
         cpu_data = 8'(8'h50 + i);
         step(1);
      end
      chk("R2 no capture on phi2-high edges", bus_stat, 8'hA2);
      sync = 1'b0;
      step(2);
      phi2 = 1'b0; cpu_data = 8'hEE;
      step(3);
      chk("R2 no capture with SYNC low", bus_stat, 8'hA2);
      sync = 1'b1; phi2 = 1'b1; cpu_data = 8'h81;
      step(1);
      phi2 = 1'b0;
      step(1);
      chk("R1 second capture", bus_stat, 8'h81);
      sync = 1'b0; phi2 = 1'b1;
      step(2);
   endtask

   task automatic t_stat_oe;
      chk("R4 status enable default", {7'd0, bus_stat_oe}, 8'd1);
      @(posedge clk); #0.5;
      stat_dis_n = 1'b0; #0.5;
      chk("R4 status enable drops at once", {7'd0, bus_stat_oe}, 8'd0);
      step(1);
      stat_dis_n = 1'b1; #0.5;
      chk("R4 status enable returns", {7'd0, bus_stat_oe}, 8'd1);
   endtask

   task automatic t_pdbin;
      step(1);
      dbin = 1'b0; dma_in_n = 1'b1; #0.5;
      chk("R5 pdbin idle", {7'd0, bus_pdbin}, 8'd0);
      dbin = 1'b1; #0.5;
      chk("R5 pdbin from dbin", {7'd0, bus_pdbin}, 8'd1);
      dbin = 1'b0; dma_in_n = 1'b0; #0.5;
      chk("R5 pdbin override", {7'd0, bus_pdbin}, 8'd1);
      chk("R8 override alone keeps dout enabled", {7'd0, bus_dout_oe}, 8'd1);
      dma_in_n = 1'b1;
   endtask

   task automatic t_ctl;
      step(1);
      sync = 1'b1; inte = 1'b0; hlda = 1'b1; wr = 1'b0; wait_in = 1'b1; #0.5;
      chk("R6 control copy A", {3'd0, bus_sync, bus_inte, bus_hlda, bus_wr, bus_wait}, 8'b10101);
      sync = 1'b0; inte = 1'b1; hlda = 1'b0; wr = 1'b1; wait_in = 1'b0; #0.5;
      chk("R6 control copy B", {3'd0, bus_sync, bus_inte, bus_hlda, bus_wr, bus_wait}, 8'b01010);
      ctl_dis_n = 1'b0; #0.5;
      chk("R6 control enable drops", {7'd0, bus_ctl_oe}, 8'd0);
      ctl_dis_n = 1'b1; #0.5;
      chk("R6 control enable returns", {7'd0, bus_ctl_oe}, 8'd1);
      inte = 1'b0; wr = 1'b0;
   endtask

   task automatic t_dout;
      step(1);
      cpu_data = 8'h6D; #0.5;
      chk("R7 dout copies data", bus_dout, 8'h6D);
      chk("R7 dout enabled by default", {7'd0, bus_dout_oe}, 8'd1);
      dout_dis_n = 1'b0; #0.5;
      chk("R7 dout disabled by master", {7'd0, bus_dout_oe}, 8'd0);
      dout_dis_n = 1'b1;
      for (int s = 0; s < NS; s++) begin
         dbin = 1'b1; src_sel = NS'(1 << s); #0.5;
         chk("R8 onboard read disables dout", {7'd0, bus_dout_oe}, 8'd0);
      end
      src_sel = '0; #0.5;
      chk("R8 external read keeps dout", {7'd0, bus_dout_oe}, 8'd1);
      dbin = 1'b0; src_sel = 3'b010; #0.5;
      chk("R8 select without dbin keeps dout", {7'd0, bus_dout_oe}, 8'd1);
      src_sel = '0;
   endtask

   initial begin : watchdog
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      t_reset();
      t_capture();
      t_phi2_high();
      t_stat_oe();
      t_pdbin();
      t_ctl();
      t_dout();
      step(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule